// File: doc/BRIEF.md
# Pixel Pack and Expand Unit

This block is the pixel-formatting datapath of a 64-bit media unit. Each cycle it may accept one operation, chosen by a 3-bit select. It takes two 64-bit source operands and a 5-bit scale field, which holds bits [7:3] of a graphics status register. It produces one 64-bit result on the following clock.

Three of the operations turn wide lanes into narrow lanes. Each of these shifts a lane left by the scale, shifts it right arithmetically by a fixed amount that depends on the operation, and saturates the lane.

- One pack turns four 16-bit lanes into bytes.
- One pack turns two 32-bit lanes into bytes. It also carries the earlier bytes of the first operand along, one byte position higher, so that a destination can be built up a byte at a time.
- One pack turns two 32-bit fixed-point lanes into signed 16-bit values.

The other two operations widen or interleave data:

- Expand turns four bytes into 16-bit fixed-point lanes.
- Merge interleaves the bytes of two 32-bit words.

Instruction decode, register files and exception handling sit outside the block. The caller raises `in_valid` with the operands. `out_valid` and `out_data` follow on the next clock. There is no back-pressure.

Top module: `pixfmt_unit`

## Requirements
- R1: With op code 0 (byte pack of 16-bit lanes), the unit treats `in_b[16i+15:16i]` as a signed value for lane i (i = 0..3). It shifts the lane left by `in_scale[3:0]`, shifts it right arithmetically by 7, and clamps it to 0..255. The result is placed in `out_data[8i+7:8i]`, and `out_data[63:32]` is zero.
- R2: With op code 1 (accumulating byte pack of 32-bit lanes), the unit treats `in_b[32w+31:32w]` as a signed value for lane w (w = 0..1). It shifts the lane left by the full `in_scale[4:0]`, shifts it right arithmetically by 23, and clamps it to 0..255. The clamped value is placed in `out_data[32w+7:32w]`.
- R3: With op code 1, `out_data[32w+31:32w+8]` equals `in_a[32w+23:32w]`. That is, the first operand is shifted left by 8, with bytes 0 and 4 replaced by the clamped lanes.
- R4: With op code 2 (fixed-point pack), the unit treats `in_b[32w+31:32w]` as a signed value for lane w. It shifts the lane left by `in_scale[4:0]`, shifts it right arithmetically by 16, and saturates it to -32768..32767. The result is placed in `out_data[16w+15:16w]`, and `out_data[63:32]` is zero.
- R5: With op code 3 (expand), byte i of `in_b[31:0]` becomes bits [11:4] of the 16-bit lane i in `out_data`. Bits [3:0] and [15:12] of every lane are zero.
- R6: With op code 4 (merge), byte k of `in_b[31:0]` lands in result byte 2k, and byte k of `in_a[31:0]` lands in result byte 2k+1.
- R7: Op codes 5, 6 and 7 are reserved. They produce an all-zero result.
- R8: `out_valid` equals the `in_valid` of the previous clock. Synchronous reset clears `out_valid` and `out_data` to zero.
- R9: While `in_valid` is low, `out_data` keeps its last value, whatever the other inputs do.
- R10: Every intermediate value is kept wide enough that no bits are lost before saturation. With the largest scale, a lane value of 1 saturates to 255 in both byte packs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request for this cycle |
| in_op | input | 3 | Operation select (0..4; 5..7 reserved) |
| in_a | input | 64 | First source operand |
| in_b | input | 64 | Second source operand |
| in_scale | input | 5 | Scale field, status register bits [7:3] |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_data | output | 64 | Registered result, zero-extended |

## Verification
The assertions in the RTL are checked on every cycle. They cover the one-clock valid timing, the reset clear, holding the result while idle, the zero upper half of the two 32-bit-result packs, the zero nibbles of expand, and the zero result of the reserved codes. Only the bench's scenarios can show that the lane values are right: the clamping at 0 and 255, signed saturation, the byte carry of the accumulating pack, the order of the interleaved bytes, and the wide intermediates at scale 15 and 31. A reference model in the bench checks each of these against directed corner vectors and a long mixed stream.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pix_op_e;

endpackage

// File: rtl/pixfmt_sat_lane.sv
// One pack lane: sign-extend, scale left, fixed arithmetic right shift, clamp.
module pixfmt_sat_lane #(
  parameter int IN_W       = 16,
  parameter int SCALE_W    = 4,
  parameter int RSH        = 7,
  parameter int OUT_W      = 8,
  parameter bit SIGNED_OUT = 1'b0
) (
  input  logic [IN_W-1:0]    lane_in,
  input  logic [SCALE_W-1:0] scale,
  output logic [OUT_W-1:0]   lane_out
);

  // Wide enough for the largest left shift with no loss.
  localparam int WW = IN_W + (1 << SCALE_W) - 1;

  logic signed [WW-1:0] widened;
  logic signed [WW-1:0] shifted;
  logic signed [WW-1:0] fixed_v;
  logic                 is_neg;

  assign widened = {{(WW-IN_W){lane_in[IN_W-1]}}, lane_in};
  assign shifted = widened <<< scale;
  assign fixed_v = shifted >>> RSH;
  assign is_neg  = fixed_v[WW-1];

  generate
    if (SIGNED_OUT) begin : g_signed
      logic hi_pos;
      logic hi_neg;
      assign hi_pos = !is_neg && (|fixed_v[WW-2:OUT_W-1]);
      assign hi_neg = is_neg && !(&fixed_v[WW-2:OUT_W-1]);
      always_comb begin
        if (hi_pos)      lane_out = {1'b0, {(OUT_W-1){1'b1}}};
        else if (hi_neg) lane_out = {1'b1, {(OUT_W-1){1'b0}}};
        else             lane_out = fixed_v[OUT_W-1:0];
      end
    end else begin : g_unsigned
      logic too_big;
      assign too_big = |fixed_v[WW-2:OUT_W];
      always_comb begin
        if (is_neg)       lane_out = '0;
        else if (too_big) lane_out = '1;
        else              lane_out = fixed_v[OUT_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/pixfmt_spread.sv
// Expand bytes into fixed-point lanes, and interleave bytes of two words.
module pixfmt_spread #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int FRAC   = 4
) (
  input  logic [LANES*BYTE_W-1:0]   word_a,
  input  logic [LANES*BYTE_W-1:0]   word_b,
  output logic [LANES*2*BYTE_W-1:0] expanded,
  output logic [LANES*2*BYTE_W-1:0] merged
);

  localparam int LANE_W = 2 * BYTE_W;
  localparam int PAD_HI = LANE_W - BYTE_W - FRAC;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign expanded[k*LANE_W +: LANE_W] =
        {{PAD_HI{1'b0}}, word_b[k*BYTE_W +: BYTE_W], {FRAC{1'b0}}};
      assign merged[k*LANE_W +: LANE_W] =
        {word_a[k*BYTE_W +: BYTE_W], word_b[k*BYTE_W +: BYTE_W]};
    end
  endgenerate

endmodule

// File: rtl/pixfmt_unit.sv
module pixfmt_unit
  import pixfmt_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SCALE_W  = 5,
  parameter int P16_RSH  = 7,
  parameter int P32_RSH  = 23,
  parameter int PFIX_RSH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [SCALE_W-1:0] in_scale,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int HALF_W = DATA_W / 2;
  localparam int N16    = DATA_W / 16;
  localparam int N32    = DATA_W / 32;
  localparam int KEEP_W = 32 - BYTE_W;

  logic [N16*BYTE_W-1:0] p16_res;
  logic [N32*BYTE_W-1:0] p32_res;
  logic [N32*16-1:0]     fix_res;
  logic [DATA_W-1:0]     acc_res;
  logic [DATA_W-1:0]     exp_res;
  logic [DATA_W-1:0]     mrg_res;
  logic [DATA_W-1:0]     result;
  logic                  unused_bits;

  // Byte pack of 16-bit lanes uses the narrow scale field.
  generate
    for (genvar i = 0; i < N16; i++) begin : g_p16
      pixfmt_sat_lane #(
        .IN_W(16), .SCALE_W(SCALE_W-1), .RSH(P16_RSH),
        .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)
      ) u_lane (
        .lane_in (in_b[i*16 +: 16]),
        .scale   (in_scale[SCALE_W-2:0]),
        .lane_out(p16_res[i*BYTE_W +: BYTE_W])
      );
    end

    for (genvar w = 0; w < N32; w++) begin : g_p32
      pixfmt_sat_lane #(
        .IN_W(32), .SCALE_W(SCALE_W), .RSH(P32_RSH),
        .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)
      ) u_lane (
        .lane_in (in_b[w*32 +: 32]),
        .scale   (in_scale),
        .lane_out(p32_res[w*BYTE_W +: BYTE_W])
      );
      // Accumulate: earlier bytes move up one byte, new byte enters at the bottom.
      assign acc_res[w*32 +: 32] = {in_a[w*32 +: KEEP_W], p32_res[w*BYTE_W +: BYTE_W]};
    end

    for (genvar w = 0; w < N32; w++) begin : g_fix
      pixfmt_sat_lane #(
        .IN_W(32), .SCALE_W(SCALE_W), .RSH(PFIX_RSH),
        .OUT_W(16), .SIGNED_OUT(1'b1)
      ) u_lane (
        .lane_in (in_b[w*32 +: 32]),
        .scale   (in_scale),
        .lane_out(fix_res[w*16 +: 16])
      );
    end
  endgenerate

  pixfmt_spread #(
    .LANES(HALF_W/BYTE_W), .BYTE_W(BYTE_W), .FRAC(4)
  ) u_spread (
    .word_a  (in_a[HALF_W-1:0]),
    .word_b  (in_b[HALF_W-1:0]),
    .expanded(exp_res),
    .merged  (mrg_res)
  );

  // Top byte of each accumulating word is shifted out.
  assign unused_bits = ^in_a[DATA_W-1 -: BYTE_W];

  always_comb begin
    case (pix_op_e'(in_op))
      OP_PACK16:  result = {{(DATA_W-N16*BYTE_W){1'b0}}, p16_res};
      OP_PACK32:  result = acc_res;
      OP_PACKFIX: result = {{(DATA_W-N32*16){1'b0}}, fix_res};
      OP_EXPAND:  result = exp_res;
      OP_MERGE:   result = mrg_res;
      default:    result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end

  // Assertions guarding the output register and result formats.
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > 3'd4) |=> (out_data == '0));

  a_r5_expand_nibbles: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd3) |=> ((out_data & 64'hF00F_F00F_F00F_F00F) == '0));

  a_r4_fix_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd2) |=> (out_data[DATA_W-1:HALF_W] == '0));

  a_r1_p16_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd0) |=> (out_data[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/test_pixfmt_unit.sv
`timescale 1ns/1ps
module test_pixfmt_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [4:0]  in_scale = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;
  logic [63:0] last_out = '0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;  // 250 MHz

  pixfmt_unit i_pixfmt_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_scale(in_scale),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [7:0] clamp_u8(input longint v);
    if (v < 0) return 8'd0;
    if (v > 255) return 8'd255;
    return v[7:0];
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [4:0] sc);
    logic [63:0] r;
    longint v;
    r = '0;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
        v = longint'($signed(b[i*16 +: 16]));
        v = (v <<< sc[3:0]) >>> 7;
        r[i*8 +: 8] = clamp_u8(v);
      end
      3'd1: begin
        r = (a << 8) & ~64'h0000_00ff_0000_00ff;
        for (int w = 0; w < 2; w++) begin
          v = longint'($signed(b[w*32 +: 32]));
          v = (v <<< sc) >>> 23;
          r[w*32 +: 8] = clamp_u8(v);
        end
      end
      3'd2: for (int w = 0; w < 2; w++) begin
        v = longint'($signed(b[w*32 +: 32]));
        v = (v <<< sc) >>> 16;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        r[w*16 +: 16] = v[15:0];
      end
      3'd3: for (int i = 0; i < 4; i++) r[i*16 +: 16] = {4'h0, b[i*8 +: 8], 4'h0};
      3'd4: for (int k = 0; k < 4; k++) r[k*16 +: 16] = {a[k*8 +: 8], b[k*8 +: 8]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [4:0] sc, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_scale = sc;
    exp_q.push_back(model(op, a, b, sc));
    tag_q.push_back(tag == "" ? op_tag(op) : tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_op = 3'($urandom); in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
    in_scale = 5'($urandom);
  endtask

  // Monitor: scoreboard compare after each edge.
  always @(posedge clk) begin
    #1;
    if (mon_en && !finished) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected out_valid", out_data, '0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data === e, t, out_data, e);
          last_out = e;
        end
      end else begin
        check(out_data === last_out, "R9 hold while idle", out_data, last_out);
      end
    end
  end

  initial begin
    // Reset: drive a request during reset, nothing may come out (R8).
    in_valid = 1'b1; in_op = 3'd4; in_a = '1; in_b = '1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R8 reset valid", {63'b0, out_valid}, '0);
    check(out_data === '0, "R8 reset data", out_data, '0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    mon_en = 1'b1;

    // R1: clamp high, exact 1, negative to 0, mid value
    drive(3'd0, '0, 64'h1234_FFFF_0080_7F80, 5'd0, "R1");
    drive(3'd0, '0, 64'h8000_7FFF_0100_0040, 5'd3, "R1");
    // R10: largest narrow scale, lane 1 -> 255
    drive(3'd0, '0, 64'h0001_0001_0001_0001, 5'd15, "R10");
    // Scale bit 4 must be ignored by the 16-bit pack (R1)
    drive(3'd0, '0, 64'h0001_0100_0040_0080, 5'd16, "R1");
    // R2: 32-bit lanes, clamp and pass-through
    drive(3'd1, '0, 64'h0080_0000_FFFF_FFFF, 5'd0, "R2");
    drive(3'd1, '0, 64'h0000_1234_7FFF_FFFF, 5'd4, "R2");
    // R10: largest wide scale, lane 1 -> 255 both lanes
    drive(3'd1, '0, 64'h0000_0001_0000_0001, 5'd31, "R10");
    // R3: byte carry of first operand
    drive(3'd1, 64'hA1B2_C3D4_E5F6_0718, 64'h0000_0000_0000_0000, 5'd0, "R3");
    drive(3'd1, 64'h1122_3344_5566_7788, 64'h0100_0000_0200_0000, 5'd2, "R3");
    // R4: signed saturation both ways and exact limits
    drive(3'd2, '0, 64'h8000_0000_7FFF_FFFF, 5'd0, "R4");
    drive(3'd2, '0, 64'h8000_0000_7FFF_FFFF, 5'd1, "R4");
    drive(3'd2, '0, 64'hFFFF_8000_0001_2345, 5'd5, "R4");
    // R5 / R6
    drive(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_FF01_80A5, 5'd9, "R5");
    drive(3'd4, 64'h0BAD_F00D_4433_2211, 64'h0BAD_F00D_DDCC_BBAA, 5'd0, "R6");
    // R7 reserved codes
    drive(3'd5, '1, '1, 5'd7, "R7");
    idle();
    drive(3'd6, '1, 64'h1234, 5'd1, "R7");
    drive(3'd7, 64'h55, '1, 5'd2, "R7");
    // R9: idle gap with changing inputs
    idle(); idle(); idle();

    // Mixed stream
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) idle();
      else drive(3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom},
                 5'($urandom), "");
    end
    idle();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 results outstanding", 64'(exp_q.size()), '0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule